// File: doc/BRIEF.md
# Dual Data Pointer Unit

This unit holds two 16-bit data pointers for an 8051-class processor core: a main pointer and a shadow pointer. A control register chooses which pointer is active and gives each pointer its own automatic step mode. The core reaches the active pointer's low and high bytes and the control register through a byte-wide special-function-register (SFR) read/write port. The active pointer's full value is always driven on an address output. Instruction decode and the memory buses live outside the unit.

When the core finishes a pointer-indirect external-data or code move, it pulses a strobe. On that strobe the active pointer steps according to its own mode: it holds, increments, decrements, or flips bit 0. If auto-toggle is on, the select bit then inverts, so the next move uses the other pointer. This lets a block copy alternate between a source and a destination address with no software bookkeeping.

Top module: `dual_dptr`

## Requirements
- R1: After reset both pointers are 0x0000, the control register reads 0x00 and `dptr_o` is 0x0000.
- R2: The control register sits at SFR address 0xA7. Its fields are: bit 0 selects the pointer (0 main, 1 shadow), bits 3:2 are the main pointer mode, bits 5:4 are the shadow pointer mode, and bit 6 enables auto-toggle. A write is read back unchanged in those bits.
- R3: Control bits 7 and 1 always read 0, whatever value is written to them.
- R4: SFR address 0x82 reads and writes the low byte of the active pointer, and 0x83 its high byte. The inactive pointer keeps its value.
- R5: On `mov_done_i`, the active pointer takes a step set by its own 2-bit mode: 00 holds, 01 adds 1, 10 subtracts 1, 11 inverts bit 0. The inactive pointer does not change.
- R6: Increment and decrement wrap modulo 2^16: 0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF.
- R7: With auto-toggle set, each `mov_done_i` inverts the select bit after the used pointer has stepped. Control reads show the live select bit.
- R8: Without `mov_done_i`, neither pointer and neither the select bit change except through SFR writes.
- R9: An SFR write wins over a same-cycle strobe for the register it targets. A pointer byte write takes the written byte and suppresses that pointer's step. A control write takes the written select bit, and no toggle happens.
- R10: `dptr_o` always equals the 16-bit value of the pointer named by the current select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | 8 | SFR address for reads and writes |
| sfr_we_i | input | 1 | SFR write enable |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data for the addressed register (0 if not owned here) |
| mov_done_i | input | 1 | Pulse: pointer-indirect data or code move completed |
| dptr_o | output | 16 | Active pointer value |

## Verification
A wrong step in either pointer shows on `dptr_o` one clock after the strobe, because the address output is the active register with no further stage. A select bit stuck or flipped the wrong way shows in the same cycle as a jump of `dptr_o` to the other pointer's value, and in bit 0 of a control read. Damage to the inactive pointer stays hidden until the select bit points back at it, so the bench switches pointers and reads both after each step sequence.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  typedef enum logic [1:0] {
    PM_HOLD = 2'b00,
    PM_INC  = 2'b01,
    PM_DEC  = 2'b10,
    PM_FLIP = 2'b11
  } ptr_mode_e;

  localparam int unsigned NUM_PTR = 2;
endpackage

// File: rtl/dptr_reg.sv
module dptr_reg
  import dptr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [7:0]   wdata_i,
  input  logic         step_i,
  input  ptr_mode_e    mode_i,
  output logic [W-1:0] val_o
);
  localparam int unsigned HW = W - 8;

  logic [W-1:0] val_q, val_nxt;

  always_comb begin
    unique case (mode_i)
      PM_INC:  val_nxt = val_q + W'(1);
      PM_DEC:  val_nxt = val_q - W'(1);
      PM_FLIP: val_nxt = val_q ^ W'(1);
      default: val_nxt = val_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      // byte write beats the step
      if (wr_lo_i) val_q[7:0]   <= wdata_i;
      if (wr_hi_i) val_q[W-1:8] <= wdata_i[HW-1:0];
    end else if (step_i) begin
      val_q <= val_nxt;
    end
  end

  assign val_o = val_q;

  assert_inc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !wr_lo_i && !wr_hi_i && mode_i == PM_INC |=> val_o == $past(val_o) + W'(1));

  assert_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !wr_lo_i && !wr_hi_i && mode_i == PM_DEC |=> val_o == $past(val_o) - W'(1));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !wr_lo_i && !wr_hi_i |=> $stable(val_o));

  assert_wr_lo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> val_o[7:0] == $past(wdata_i));
endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  logic [7:0] wdata_i,
  input  logic      flip_i,
  output logic      sel_o,
  output logic      auto_o,
  output ptr_mode_e mode_main_o,
  output ptr_mode_e mode_sh_o,
  output logic [7:0] rd_o
);
  logic      sel_q, auto_q;
  ptr_mode_e mode_main_q, mode_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= 1'b0;
      auto_q      <= 1'b0;
      mode_main_q <= PM_HOLD;
      mode_sh_q   <= PM_HOLD;
    end else if (wr_i) begin
      sel_q       <= wdata_i[0];
      mode_main_q <= ptr_mode_e'(wdata_i[3:2]);
      mode_sh_q   <= ptr_mode_e'(wdata_i[5:4]);
      auto_q      <= wdata_i[6];
    end else if (flip_i) begin
      sel_q <= ~sel_q;
    end
  end

  assign sel_o       = sel_q;
  assign auto_o      = auto_q;
  assign mode_main_o = mode_main_q;
  assign mode_sh_o   = mode_sh_q;
  assign rd_o        = {1'b0, auto_q, mode_sh_q, mode_main_q, 1'b0, sel_q};

  assert_flip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_i && !wr_i |=> sel_o != $past(sel_o));

  assert_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rd_o == ($past(wdata_i) & 8'h7D));
endmodule

// File: rtl/dual_dptr.sv
module dual_dptr
  import dptr_pkg::*;
#(
  parameter int unsigned  ADDR_W    = 16,
  parameter logic [7:0]   LO_ADDR   = 8'h82,
  parameter logic [7:0]   HI_ADDR   = 8'h83,
  parameter logic [7:0]   CTRL_ADDR = 8'hA7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        sfr_addr_i,
  input  logic              sfr_we_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic [7:0]        sfr_rdata_o,
  input  logic              mov_done_i,
  output logic [ADDR_W-1:0] dptr_o
);
  localparam int unsigned HW = ADDR_W - 8;

  logic        sel, auto_tgl, ctrl_we;
  logic [7:0]  ctrl_rd;
  ptr_mode_e   mode_main, mode_sh;
  ptr_mode_e   mode_a [NUM_PTR];
  logic [ADDR_W-1:0] ptr_val [NUM_PTR];

  assign ctrl_we = sfr_we_i && sfr_addr_i == CTRL_ADDR;

  dptr_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (ctrl_we),
    .wdata_i     (sfr_wdata_i),
    .flip_i      (mov_done_i && auto_tgl),
    .sel_o       (sel),
    .auto_o      (auto_tgl),
    .mode_main_o (mode_main),
    .mode_sh_o   (mode_sh),
    .rd_o        (ctrl_rd)
  );

  assign mode_a[0] = mode_main;
  assign mode_a[1] = mode_sh;

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic act;
    assign act = (sel == 1'(i));

    dptr_reg #(.W(ADDR_W)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_lo_i (act && sfr_we_i && sfr_addr_i == LO_ADDR),
      .wr_hi_i (act && sfr_we_i && sfr_addr_i == HI_ADDR),
      .wdata_i (sfr_wdata_i),
      .step_i  (act && mov_done_i),
      .mode_i  (mode_a[i]),
      .val_o   (ptr_val[i])
    );
  end

  assign dptr_o = ptr_val[sel];

  always_comb begin
    unique case (sfr_addr_i)
      LO_ADDR:   sfr_rdata_o = dptr_o[7:0];
      HI_ADDR:   sfr_rdata_o = 8'(dptr_o[ADDR_W-1:8]);
      CTRL_ADDR: sfr_rdata_o = ctrl_rd;
      default:   sfr_rdata_o = 8'h00;
    endcase
  end

  // inactive pointer untouched by the active one's step or byte writes
  assert_idle_main_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel |=> $stable(ptr_val[0]));

  assert_idle_sh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> $stable(ptr_val[1]));

  assert_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we && !(mov_done_i && auto_tgl) |=> $stable(sel));
endmodule

// File: tb/sim_dual_dptr.sv
module sim_dual_dptr;
  localparam int PERIOD = 10;

  typedef struct {
    string       req;
    logic [7:0]  exp_rd;
    logic [15:0] exp_adr;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        mov_done = 1'b0;
  logic [15:0] dptr;
  logic        mon_req = 1'b0;
  item_t       q [$];
  int          total = 0;
  int          bad = 0;

  always #(PERIOD/2) clk = ~clk;

  dual_dptr u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sfr_addr_i  (sfr_addr),
    .sfr_we_i    (sfr_we),
    .sfr_wdata_i (sfr_wdata),
    .sfr_rdata_o (sfr_rdata),
    .mov_done_i  (mov_done),
    .dptr_o      (dptr)
  );

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (mon_req && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total += 2;
      if (sfr_rdata !== it.exp_rd) begin
        bad++;
        $display("FAIL %s rdata @%h: got %h exp %h", it.req, sfr_addr, sfr_rdata, it.exp_rd);
      end
      if (dptr !== it.exp_adr) begin
        bad++;
        $display("FAIL %s dptr_o: got %h exp %h", it.req, dptr, it.exp_adr);
      end
    end
  end

  task automatic op(input logic [7:0] a, input logic we, input logic [7:0] d, input logic acc);
    sfr_addr = a; sfr_we = we; sfr_wdata = d; mov_done = acc;
    @(posedge clk); #1;
    sfr_we = 1'b0; mov_done = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    op(a, 1'b1, d, 1'b0);
  endtask

  task automatic strobe();
    op(8'h00, 1'b0, 8'h00, 1'b1);
  endtask

  task automatic chk(input string r, input logic [7:0] a, input logic [7:0] erd, input logic [15:0] eadr);
    item_t it;
    it.req = r; it.exp_rd = erd; it.exp_adr = eadr;
    sfr_addr = a;
    q.push_back(it);
    mon_req = 1'b1;
    @(posedge clk); #1;
    mon_req = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    chk("R1", 8'hA7, 8'h00, 16'h0000);
    chk("R1", 8'h82, 8'h00, 16'h0000);
    wr(8'h82, 8'h34); wr(8'h83, 8'h12);
    chk("R4", 8'h82, 8'h34, 16'h1234);
    chk("R4", 8'h83, 8'h12, 16'h1234);
    wr(8'hA7, 8'hFF);
    chk("R3", 8'hA7, 8'h7D, 16'h0000);       // R10: shadow now active
    wr(8'hA7, 8'h01); wr(8'h82, 8'hCD); wr(8'h83, 8'hAB);
    chk("R4", 8'h82, 8'hCD, 16'hABCD);
    wr(8'hA7, 8'h00);
    chk("R10", 8'h83, 8'h12, 16'h1234);
    strobe();
    chk("R5", 8'h82, 8'h34, 16'h1234);       // mode 00 holds
    wr(8'hA7, 8'h04); strobe();
    chk("R5", 8'h82, 8'h35, 16'h1235);
    op(8'h00, 1'b0, 8'h00, 1'b0); op(8'h00, 1'b0, 8'h00, 1'b0);
    chk("R8", 8'h82, 8'h35, 16'h1235);
    wr(8'hA7, 8'h08); strobe();
    chk("R5", 8'h82, 8'h34, 16'h1234);
    wr(8'hA7, 8'h0C); strobe();
    chk("R5", 8'h82, 8'h35, 16'h1235);
    strobe();
    chk("R5", 8'h82, 8'h34, 16'h1234);
    wr(8'hA7, 8'h04); wr(8'h82, 8'hFF); wr(8'h83, 8'hFF); strobe();
    chk("R6", 8'h83, 8'h00, 16'h0000);
    wr(8'hA7, 8'h08); strobe();
    chk("R6", 8'h82, 8'hFF, 16'hFFFF);
    wr(8'hA7, 8'h11); strobe();
    chk("R5", 8'h82, 8'hCE, 16'hABCE);
    wr(8'hA7, 8'h10);
    chk("R4", 8'h83, 8'hFF, 16'hFFFF);       // main untouched by shadow step
    wr(8'hA7, 8'h55);
    chk("R2", 8'hA7, 8'h55, 16'hABCE);
    strobe();
    chk("R7", 8'hA7, 8'h54, 16'hFFFF);
    strobe();
    chk("R7", 8'hA7, 8'h55, 16'hABCF);
    op(8'h82, 1'b1, 8'h00, 1'b1);           // byte write beats step, toggle still occurs
    chk("R9", 8'hA7, 8'h54, 16'h0000);
    wr(8'hA7, 8'h55);
    chk("R9", 8'h82, 8'h00, 16'hAB00);
    op(8'hA7, 1'b1, 8'h45, 1'b1);           // ctrl write beats toggle, step uses old mode
    chk("R9", 8'hA7, 8'h45, 16'hAB01);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule